// File: doc/BRIEF.md
# Triple-Redundant Latching Load Power Switch Controller

This block is the digital side of a switched current limiter that protects one load. A single enable bit drives the external power switch. Raising a restart request turns the switch on and opens a blanking window of a fixed number of clock cycles. During that window the overcurrent flag is ignored so that inrush current can settle. Once the window has closed, an overcurrent flag turns the switch off. The switch then stays off until the next restart request.

To tolerate upsets, the controller is built as several identical lanes (three by default). Each lane runs on its own clock, usually a phase-shifted copy from a PLL, and has its own synchronous reset and its own restart wire. The overcurrent flag is shared by all lanes. Each lane brings the asynchronous flag and its restart wire into its own domain through two-flop synchronizers. The lane enables are combined by a majority voter that drives the single output pin, so one lane that is wrong cannot change the pin.

Top module: `tmr_current_limit_ctrl`

## Requirements
- R1: While a lane's reset is high at its clock edge, that lane's enable is cleared. After reset of all lanes, enable_o is 0 until a restart request.
- R2: A rising edge on a lane's start input sets that lane's enable three of its clock edges later: two synchronizer stages plus the enable register.
- R3: For BLANK_CYCLES clock edges after the edge that sets the enable, the overcurrent input has no effect on that lane.
- R4: After the blanking window, a high overcurrent input clears the lane enable at the third clock edge after it is applied (two synchronizer stages plus the enable register). This is 12 ns at 250 MHz.
- R5: An enable that has been cleared stays 0 after the overcurrent input returns low, until a new start rising edge.
- R6: A start input held high triggers only once. After a trip, the enable stays 0 while start is still held.
- R7: A start rising edge while the enable is already 1 reloads the full blanking window.
- R8: enable_o is 1 exactly when a strict majority of the lane enables is 1. A single lane that is held in reset, or that misses its start, does not change enable_o.
- R9: Each lane's reset and start act only on that lane. The other lanes keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | NUM_LANES | One clock per lane, phase-shifted copies |
| rst_i | input | NUM_LANES | Active-high reset per lane, synchronous to that lane's clock |
| sense_i | input | 1 | Asynchronous overcurrent flag, high = overcurrent, shared by all lanes |
| start_i | input | NUM_LANES | Asynchronous restart request per lane, acts on its rising edge |
| enable_o | output | 1 | Voted power-switch enable, high = load powered |

## Verification
The hardest situation to reach from the ports is lanes that disagree. In normal use every lane receives the same reset and start, so the voter always sees unanimous inputs. The stimulus therefore holds one lane in reset while the others restart, restarts only one lane, and later resets a single lane that is running. This shows that a lone divergent lane is outvoted and that a second divergent lane changes the pin. A second hard case is the exact edge of the blanking window. The overcurrent flag is kept high across a restart issued while the switch is on, so the bench can see the trip happen only when the reloaded window ends.

// File: rtl/tmr_cl_pkg.sv
package tmr_cl_pkg;

  // Number of set bits in a lane vector (lanes are few, a loop is cheap).
  function automatic int unsigned ones_in(input logic [31:0] vec, input int unsigned width);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < width; i++) begin
      if (vec[i]) acc++;
    end
    return acc;
  endfunction

endpackage

// File: rtl/tmr_cl_sync.sv
module tmr_cl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_cl_lane.sv
module tmr_cl_lane #(
  parameter int BLANK_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sense_async,
  input  logic start_async,
  output logic en_o
);
  localparam int CW = $clog2(BLANK_CYCLES + 1);
  localparam logic [CW-1:0] BLANK_LOAD = CW'(BLANK_CYCLES);

  logic          sense_s;
  logic          start_s;
  logic          start_prev_q;
  logic          start_edge;
  logic [CW-1:0] blank_q;
  logic          en_q;

  tmr_cl_sync #(.STAGES(SYNC_STAGES)) sense_sync_i (
    .clk(clk), .rst(rst), .d_async(sense_async), .q_sync(sense_s)
  );

  tmr_cl_sync #(.STAGES(SYNC_STAGES)) start_sync_i (
    .clk(clk), .rst(rst), .d_async(start_async), .q_sync(start_s)
  );

  assign start_edge = start_s & ~start_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_prev_q <= 1'b0;
      blank_q      <= '0;
      en_q         <= 1'b0;
    end else begin
      start_prev_q <= start_s;
      if (start_edge) begin
        en_q    <= 1'b1;
        blank_q <= BLANK_LOAD;
      end else if (blank_q != '0) begin
        blank_q <= blank_q - 1'b1;
      end else if (sense_s) begin
        en_q <= 1'b0;
      end
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/tmr_cl_voter.sv
module tmr_cl_voter #(
  parameter int NUM_LANES = 3
) (
  input  logic [NUM_LANES-1:0] votes,
  output logic                 maj
);
  import tmr_cl_pkg::*;
  localparam int unsigned NEED = (NUM_LANES / 2) + 1;

  always_comb begin
    maj = (ones_in(32'(votes), NUM_LANES) >= NEED);
  end
endmodule

// File: rtl/tmr_current_limit_ctrl.sv
module tmr_current_limit_ctrl #(
  parameter int NUM_LANES    = 3,
  parameter int BLANK_CYCLES = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic [NUM_LANES-1:0] clk_i,
  input  logic [NUM_LANES-1:0] rst_i,
  input  logic                 sense_i,
  input  logic [NUM_LANES-1:0] start_i,
  output logic                 enable_o
);
  logic [NUM_LANES-1:0] lane_en;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    tmr_cl_lane #(
      .BLANK_CYCLES(BLANK_CYCLES),
      .SYNC_STAGES (SYNC_STAGES)
    ) lane_i (
      .clk        (clk_i[g]),
      .rst        (rst_i[g]),
      .sense_async(sense_i),
      .start_async(start_i[g]),
      .en_o       (lane_en[g])
    );
  end

  tmr_cl_voter #(.NUM_LANES(NUM_LANES)) voter_i (
    .votes(lane_en),
    .maj  (enable_o)
  );
endmodule

// File: rtl/tmr_cl_checker.sv
module tmr_cl_checker #(
  parameter int NUM_LANES    = 3,
  parameter int BLANK_CYCLES = 16
) (
  input logic [NUM_LANES-1:0] clk_i,
  input logic [NUM_LANES-1:0] rst_i,
  input logic                 sense_i,
  input logic [NUM_LANES-1:0] start_i,
  input logic [NUM_LANES-1:0] lane_en,
  input logic                 enable_o
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_chk
    logic [3:0] st_sh;
    logic [1:0] se_sh;
    int         win;
    logic       st_edge;

    assign st_edge = st_sh[1] & ~st_sh[2];

    always_ff @(posedge clk_i[g]) begin
      if (rst_i[g]) begin
        st_sh <= '0;
        se_sh <= '0;
        win   <= 0;
      end else begin
        st_sh <= {st_sh[2:0], start_i[g]};
        se_sh <= {se_sh[0], sense_i};
        if (st_edge)      win <= BLANK_CYCLES;
        else if (win > 0) win <= win - 1;
      end
    end

    // R5: a lane can only come on right after a synchronized start edge
    p_on_needs_start_r5: assert property (@(posedge clk_i[g]) disable iff (rst_i[g])
      $rose(lane_en[g]) |-> (st_sh[2] && !st_sh[3]));

    // R3: inside the blanking window the lane stays on
    p_blank_holds_r3: assert property (@(posedge clk_i[g]) disable iff (rst_i[g])
      (win > 0) |-> lane_en[g]);

    // R4: synchronized overcurrent outside the window trips at the next edge
    p_trip_r4: assert property (@(posedge clk_i[g]) disable iff (rst_i[g])
      (win == 0 && se_sh[1] && !st_edge) |=> !lane_en[g]);
  end

  // R8: unanimous lanes decide the pin
  always_comb begin
    if (&lane_en) p_vote_all_on_r8: assert (enable_o);
    if (lane_en == '0) p_vote_all_off_r8: assert (!enable_o);
  end
endmodule

bind tmr_current_limit_ctrl tmr_cl_checker #(
  .NUM_LANES   (NUM_LANES),
  .BLANK_CYCLES(BLANK_CYCLES)
) chk_i (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .sense_i (sense_i),
  .start_i (start_i),
  .lane_en (lane_en),
  .enable_o(enable_o)
);

// File: tb/tmr_current_limit_ctrl_tb.sv
`timescale 1ns/1ps
module tmr_current_limit_ctrl_tb_top;
  localparam int BLANK = 16;

  logic [2:0] clk;
  logic [2:0] rst;
  logic [2:0] start;
  logic       sense;
  logic       enable_o;

  int    n_tests;
  int    n_fail;
  bit    done;
  string tag;

  // reference model state per lane
  int m_s1[3], m_s2[3], m_t1[3], m_t2[3], m_t3[3], m_cnt[3], m_en[3];

  tmr_current_limit_ctrl #(.NUM_LANES(3), .BLANK_CYCLES(BLANK)) dut_i (
    .clk_i(clk), .rst_i(rst), .sense_i(sense), .start_i(start), .enable_o(enable_o)
  );

  // 250 MHz lanes; rising edges at +0, +1, +2 ns relative to lane 0
  initial begin clk[0] = 1'b0; forever #2 clk[0] = ~clk[0]; end
  initial begin clk[1] = 1'b0; #1 forever #2 clk[1] = ~clk[1]; end
  initial begin clk[2] = 1'b0; #2 forever #2 clk[2] = ~clk[2]; end

  task automatic model_tick();
    for (int k = 0; k < 3; k++) begin
      if (rst[k]) begin
        m_s1[k] = 0; m_s2[k] = 0; m_t1[k] = 0; m_t2[k] = 0; m_t3[k] = 0;
        m_cnt[k] = 0; m_en[k] = 0;
      end else begin
        int pulse;
        int old_s1, old_s2, old_t1, old_t2;
        pulse  = (m_t2[k] == 1 && m_t3[k] == 0) ? 1 : 0;
        old_s1 = m_s1[k]; old_s2 = m_s2[k]; old_t1 = m_t1[k]; old_t2 = m_t2[k];
        if (pulse == 1) begin
          m_en[k] = 1; m_cnt[k] = BLANK;
        end else if (m_cnt[k] > 0) begin
          m_cnt[k] = m_cnt[k] - 1;
        end else if (old_s2 == 1) begin
          m_en[k] = 0;
        end
        m_s1[k] = int'(sense); m_s2[k] = old_s1;
        m_t3[k] = old_t2; m_t2[k] = old_t1; m_t1[k] = int'(start[k]);
      end
    end
  endtask

  task automatic step();
    int   votes;
    logic exp;
    @(posedge clk[0]);
    #3;
    model_tick();
    votes = m_en[0] + m_en[1] + m_en[2];
    exp   = (votes >= 2);
    n_tests++;
    if (enable_o !== exp) begin
      n_fail++;
      $display("FAIL %s: enable_o actual=%b expected=%b at %0t", tag, enable_o, exp, $time);
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_start(input logic [2:0] which);
    start = which; step(); step();
    start = 3'b000;
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 0;
    rst = 3'b111; start = 3'b000; sense = 1'b0;
    // R1: reset state and idle after reset
    tag = "R1"; run(4);
    rst = 3'b000; run(6);
    // R2: start edge powers the load after the sync latency
    tag = "R2"; pulse_start(3'b111); run(6);
    // R3: overcurrent inside the blanking window is ignored
    tag = "R3"; sense = 1'b1; run(5); sense = 1'b0; run(12);
    // R4: overcurrent after the window trips the switch
    tag = "R4"; sense = 1'b1; run(6);
    // R5: stays off after overcurrent clears
    tag = "R5"; sense = 1'b0; run(25);
    // R6: held start triggers once only
    tag = "R6"; start = 3'b111; run(24);
    sense = 1'b1; run(4); sense = 1'b0; run(30);
    start = 3'b000; run(4);
    // R7: restart while on reloads the blanking window
    tag = "R7"; pulse_start(3'b111); run(9);
    pulse_start(3'b111); sense = 1'b1; run(30);
    sense = 1'b0; run(3);
    // R8: one lane held in reset is outvoted
    tag = "R8"; rst = 3'b010; pulse_start(3'b111); run(24);
    sense = 1'b1; run(6); sense = 1'b0; rst = 3'b000; run(4);
    // R8: only one lane restarted -> pin stays off
    pulse_start(3'b001); run(8);
    // R8: second lane joins -> majority on
    pulse_start(3'b010); run(8);
    // R9: resetting one running lane affects only that lane
    tag = "R9"; pulse_start(3'b100); run(4);
    rst = 3'b001; run(3); rst = 3'b000; run(6);
    rst = 3'b010; run(3); rst = 3'b000; run(6);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule